// File: doc/BRIEF.md
# Sense-configurable GPIO interrupt controller

This block watches a bank of general-purpose input pins and turns selected transitions or levels on them into one interrupt line. Every pin carries its own 4-bit sense field, so one pin can react to a rising edge while a neighbour reacts to a low level or to both edges. Pin samples pass through a synchroniser before detection. Each detected event sets a sticky pending bit that software clears by writing a one.

Software controls the block through a plain 32-bit register port: a write strobe, a byte address and write data, with read data returned combinationally for the current address. The port has no back-pressure, because every access finishes in the cycle it is issued. Interrupt masking uses two strobe registers, one to set enable bits and one to clear them. A separate acceptance mask decides which pins may reach the detector at all. A handler reads the masked status register, services the lowest set bit, clears it, and repeats until status reads zero. Before a pin's sense field is changed, its acceptance bit is cleared and its pending bit is cleared, and then acceptance is set again.

Top module: `gpio_sense_irq`

## Requirements
- R1: After reset the enable, acceptance and pending registers read zero, every sense register reads 0x88888888 (all pins rising edge), and `irq_o` is low.
- R2: A write to EN_SET (0x00) sets each enable bit whose data bit is one. A write to EN_CLR (0x04) clears each enable bit whose data bit is one. Zero data bits leave their enable bits unchanged. Reads of either address return the enable mask.
- R3: The sense field of pin n sits in the sense register at 0x20 + 4*(n/8), bits (n mod 8)*4 +: 4. The field is stored and read back in full. Bits [2:0] select the mode: 0 rising edge, 1 falling edge, 2 high level, 3 low level, 4 both edges, 5 to 7 no detection. Bit 3 is the asynchronous flag, written as one in normal use (values 8 to 12), and it does not change detection.
- R4: In the edge modes, one qualifying transition of the synchronised pin sets the pending bit once. After a clear, the bit stays clear until the next qualifying transition.
- R5: In the level modes, the pending bit is set on every cycle while the level holds. A clear written during that time has no lasting effect.
- R6: A pin whose acceptance bit (ACCEPT, 0x08, read/write) is zero never sets its pending bit, whatever it does. Setting acceptance later while the pin holds steady at a level that an edge mode ignores produces no event.
- R7: Writing a one to a bit of PEND (0x0C) clears that pending bit. Zero bits have no effect. An event in the same cycle as the clear wins, and the bit stays set.
- R8: STATUS (0x10) reads pending AND enable. RAW_LO (0x50) returns pending bits 15:0 in its bits 15:0, and RAW_HI (0x54) returns pending bits 31:16 in its bits 15:0. The upper halves of both, and any unmapped address, read zero.
- R9: A pin change that is set up before clock edge k shows in the pending register after edge k+2. `irq_o` is the OR of all status bits, registered, so it follows status one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Raw pin inputs, asynchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
On every cycle, the in-line assertions check four things: that a set or clear strobe changes only the addressed enable bits, that a one-write really clears a pending bit unless an event arrives, that no pending bit rises without a detected event, and that every detected event lands in pending. They also check that each change of `irq_o` follows the status of the cycle before. The bench scenarios are needed for the rest: the meaning of each sense code at its field position, the exact synchroniser latency, acceptance gating, level re-assertion against clears, and the split of pending bits across the two raw-event registers. A randomised run compares every readable register and the interrupt line with a cycle-accurate model on each cycle.

// File: rtl/gsi_pkg.sv
package gsi_pkg;

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CODE_W  = 3;

  localparam logic [FIELD_W-1:0] SENSE_RESET = 4'h8;

  typedef enum logic [CODE_W-1:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  localparam logic [7:0] ADR_EN_SET = 8'h00;
  localparam logic [7:0] ADR_EN_CLR = 8'h04;
  localparam logic [7:0] ADR_ACCEPT = 8'h08;
  localparam logic [7:0] ADR_PEND   = 8'h0C;
  localparam logic [7:0] ADR_STATUS = 8'h10;
  localparam logic [7:0] ADR_SENSE0 = 8'h20;
  localparam logic [7:0] ADR_RAW_LO = 8'h50;
  localparam logic [7:0] ADR_RAW_HI = 8'h54;

endpackage

// File: rtl/gsi_sync.sv
module gsi_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cur,
  output logic [WIDTH-1:0] prev
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= stage[STAGES-1];
  end

  assign cur = stage[STAGES-1];

endmodule

// File: rtl/gsi_detect.sv
module gsi_detect
  import gsi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0]        cur,
  input  logic [NUM_PINS-1:0]        prev,
  input  logic [NUM_PINS-1:0]        accept,
  input  logic [NUM_PINS*CODE_W-1:0] mode_flat,
  output logic [NUM_PINS-1:0]        evt
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              hit;

    assign code = mode_flat[p*CODE_W +: CODE_W];

    always_comb begin
      case (code)
        SNS_RISE: hit = cur[p] & ~prev[p];
        SNS_FALL: hit = ~cur[p] & prev[p];
        SNS_HIGH: hit = cur[p];
        SNS_LOW:  hit = ~cur[p];
        SNS_BOTH: hit = cur[p] ^ prev[p];
        default:  hit = 1'b0;
      endcase
    end

    assign evt[p] = accept[p] & hit;
  end

endmodule

// File: rtl/gsi_regs.sv
module gsi_regs
  import gsi_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [7:0]                  addr,
  input  logic [NUM_PINS-1:0]         wdata,
  input  logic [NUM_PINS-1:0]         evt,
  output logic [NUM_PINS-1:0]         en,
  output logic [NUM_PINS-1:0]         accept,
  output logic [NUM_PINS-1:0]         pend,
  output logic [NUM_PINS*CODE_W-1:0]  mode_flat,
  output logic [NUM_PINS-1:0]         rdata
);

  localparam int unsigned FPR    = NUM_PINS / FIELD_W;
  localparam int unsigned NSENSE = NUM_PINS / FPR;
  localparam int unsigned HALF   = NUM_PINS / 2;

  logic [NUM_PINS*FIELD_W-1:0] sense_flat;
  logic [NUM_PINS-1:0]         pend_clr;
  logic                        wr_set, wr_clr, wr_acc, wr_pend;

  assign wr_set  = we && (addr == ADR_EN_SET);
  assign wr_clr  = we && (addr == ADR_EN_CLR);
  assign wr_acc  = we && (addr == ADR_ACCEPT);
  assign wr_pend = we && (addr == ADR_PEND);
  assign pend_clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en <= '0;
    else if (wr_set) en <= en | wdata;
    else if (wr_clr) en <= en & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      accept <= '0;
    else if (wr_acc) accept <= wdata;
  end

  // event wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~pend_clr) | evt;
  end

  for (genvar k = 0; k < NSENSE; k++) begin : g_sns
    localparam logic [7:0] SNS_ADDR = ADR_SENSE0 + 8'(4 * k);
    logic [NUM_PINS-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      q <= {FPR{SENSE_RESET}};
      else if (we && addr == SNS_ADDR) q <= wdata;
    end
    assign sense_flat[k*NUM_PINS +: NUM_PINS] = q;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_mode
    assign mode_flat[p*CODE_W +: CODE_W] = sense_flat[p*FIELD_W +: CODE_W];
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADR_EN_SET, ADR_EN_CLR: rdata = en;
      ADR_ACCEPT:             rdata = accept;
      ADR_PEND:               rdata = pend;
      ADR_STATUS:             rdata = pend & en;
      ADR_RAW_LO:             rdata = {{(NUM_PINS-HALF){1'b0}}, pend[HALF-1:0]};
      ADR_RAW_HI:             rdata = {{(NUM_PINS-HALF){1'b0}}, pend[NUM_PINS-1:HALF]};
      default: begin
        for (int k = 0; k < NSENSE; k++) begin
          if (addr == ADR_SENSE0 + 8'(4 * k))
            rdata = sense_flat[k*NUM_PINS +: NUM_PINS];
        end
      end
    endcase
  end

  // R2
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en & $past(wdata)) == $past(wdata)));
  // R2
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en & $past(wdata)) == '0));
  // R2
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |=> (((en ^ $past(en)) & ~$past(wdata)) == '0));
  // R7
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend & $past(wdata) & ~$past(evt)) == '0));
  // R6
  pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(evt)) == '0));
  // R5
  evt_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (($past(evt) & ~pend) == '0));

endmodule

// File: rtl/gpio_sense_irq.sv
module gpio_sense_irq
  import gsi_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_we,
  input  logic [7:0]          bus_addr,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  output logic                irq_o
);

  logic [NUM_PINS-1:0]        cur, prev, evt, en, accept, pend, status;
  logic [NUM_PINS*CODE_W-1:0] mode_flat;

  gsi_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_i),
    .cur  (cur),
    .prev (prev)
  );

  gsi_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .cur      (cur),
    .prev     (prev),
    .accept   (accept),
    .mode_flat(mode_flat),
    .evt      (evt)
  );

  gsi_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .evt      (evt),
    .en       (en),
    .accept   (accept),
    .pend     (pend),
    .mode_flat(mode_flat),
    .rdata    (bus_rdata)
  );

  assign status = pend & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |status;
  end

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(status != '0));
  // R9
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(status == '0));

endmodule

// File: tb/gpio_sense_irq_test.sv
`timescale 1ns/1ps
module gpio_sense_irq_test;
  import gsi_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_i = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = ADR_STATUS;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  gpio_sense_irq uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // cycle-accurate reference model built from the requirements
  logic [31:0] m_s1, m_s2, m_prev, m_pend, m_en, m_acc;
  logic [31:0] m_sns [4];
  logic        m_irq;

  function automatic logic hit(logic [3:0] f, logic c, logic p);
    case (f[2:0])
      3'd0: return c & ~p;
      3'd1: return ~c & p;
      3'd2: return c;
      3'd3: return ~c;
      3'd4: return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] ev;
    logic [31:0] clr;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_en = '0; m_acc = '0;
      m_irq = 1'b0;
      for (int k = 0; k < 4; k++) m_sns[k] = 32'h8888_8888;
    end else begin
      for (int p = 0; p < 32; p++)
        ev[p] = m_acc[p] & hit(m_sns[p/8][(p%8)*4 +: 4], m_s2[p], m_prev[p]);
      m_irq = |(m_pend & m_en);
      clr = (bus_we && bus_addr == ADR_PEND) ? bus_wdata : '0;
      m_pend = (m_pend & ~clr) | ev;
      if (bus_we) begin
        if (bus_addr == ADR_EN_SET) m_en = m_en | bus_wdata;
        if (bus_addr == ADR_EN_CLR) m_en = m_en & ~bus_wdata;
        if (bus_addr == ADR_ACCEPT) m_acc = bus_wdata;
        for (int k = 0; k < 4; k++)
          if (bus_addr == ADR_SENSE0 + 8'(4 * k)) m_sns[k] = bus_wdata;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      ADR_EN_SET, ADR_EN_CLR: return m_en;
      ADR_ACCEPT: return m_acc;
      ADR_PEND:   return m_pend;
      ADR_STATUS: return m_pend & m_en;
      ADR_RAW_LO: return {16'h0, m_pend[15:0]};
      ADR_RAW_HI: return {16'h0, m_pend[31:16]};
      8'h20: return m_sns[0];
      8'h24: return m_sns[1];
      8'h28: return m_sns[2];
      8'h2C: return m_sns[3];
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ADR_STATUS;
  endtask

  task automatic rd_chk(string tag, logic [7:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] rand_sense();
    logic [31:0] v;
    for (int f = 0; f < 8; f++)
      v[f*4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : {1'b1, 3'($urandom % 5)};
    return v;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] rd_addrs [11];
    rd_addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h50, 8'h54};
    void'($urandom(32'd1234));

    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 enable", ADR_EN_SET, 32'h0);
    rd_chk("R1 accept", ADR_ACCEPT, 32'h0);
    rd_chk("R1 pending", ADR_PEND, 32'h0);
    for (int k = 0; k < 4; k++) rd_chk("R1 sense", ADR_SENSE0 + 8'(4 * k), 32'h8888_8888);
    chk("R1 irq", {31'h0, irq_o}, 32'h0);

    // R2 set/clear strobes
    wr(ADR_EN_SET, 32'h0000_00F0);
    wr(ADR_EN_SET, 32'h0000_0003);
    rd_chk("R2 set", ADR_EN_SET, 32'h0000_00F3);
    wr(ADR_EN_CLR, 32'h0000_0021);
    rd_chk("R2 clear", ADR_EN_SET, 32'h0000_00D2);
    rd_chk("R2 clear addr read", ADR_EN_CLR, 32'h0000_00D2);

    // R3 field position: pin 13 high level, register 0x24 bits 23:20
    wr(8'h24, 32'h88A8_8888);
    rd_chk("R3 readback", 8'h24, 32'h88A8_8888);
    wr(ADR_EN_SET, 32'h0000_2000);
    wr(ADR_ACCEPT, 32'h0000_2000);
    pin_i[13] = 1'b1;
    wait_n(4);
    rd_chk("R3 pin13 high level", ADR_PEND, 32'h0000_2000);

    // R5 level re-asserts against a clear, R7 clear after level ends
    wr(ADR_PEND, 32'h0000_2000);
    rd_chk("R5 clear while level held", ADR_PEND, 32'h0000_2000);
    pin_i[13] = 1'b0;
    wait_n(4);
    wr(ADR_PEND, 32'h0000_0000);
    rd_chk("R7 zero write no effect", ADR_PEND, 32'h0000_2000);
    wr(ADR_PEND, 32'h0000_2000);
    rd_chk("R7 one write clears", ADR_PEND, 32'h0);

    // R6 acceptance gating
    pin_i[2] = 1'b1;
    wait_n(5);
    rd_chk("R6 gated rise", ADR_PEND, 32'h0);
    wr(ADR_ACCEPT, 32'h0000_2004);
    wait_n(4);
    rd_chk("R6 accept on steady high", ADR_PEND, 32'h0);
    pin_i[2] = 1'b0;
    wait_n(4);
    rd_chk("R6 fall ignored in rise mode", ADR_PEND, 32'h0);

    // R4 falling on pin 4, both edges on pin 20
    wr(8'h20, 32'h8889_8888);
    wr(8'h28, 32'h888C_8888);
    wr(ADR_ACCEPT, 32'h0010_0010);
    pin_i[4] = 1'b1;
    wait_n(4);
    rd_chk("R4 rise ignored in fall mode", ADR_PEND, 32'h0);
    pin_i[4] = 1'b0;
    wait_n(4);
    rd_chk("R4 fall latched", ADR_PEND, 32'h0000_0010);
    wr(ADR_PEND, 32'h0000_0010);
    wait_n(3);
    rd_chk("R4 no re-assert after clear", ADR_PEND, 32'h0);
    pin_i[20] = 1'b1;
    wait_n(4);
    rd_chk("R4 both-edge rise", ADR_PEND, 32'h0010_0000);
    wr(ADR_PEND, 32'h0010_0000);
    pin_i[20] = 1'b0;
    wait_n(4);
    rd_chk("R4 both-edge fall", ADR_PEND, 32'h0010_0000);
    pin_i[4] = 1'b1;
    wait_n(3);
    pin_i[4] = 1'b0;
    wait_n(4);

    // R8 status and raw halves (enable = 0x20D2)
    rd_chk("R8 status", ADR_STATUS, 32'h0000_0010);
    rd_chk("R8 raw low", ADR_RAW_LO, 32'h0000_0010);
    rd_chk("R8 raw high", ADR_RAW_HI, 32'h0000_0010);
    rd_chk("R8 unmapped", 8'h40, 32'h0);
    chk("R9 irq high", {31'h0, irq_o}, 32'h1);
    wr(ADR_EN_CLR, 32'h0000_0010);
    rd_chk("R8 status masked", ADR_STATUS, 32'h0);
    @(negedge clk);
    chk("R9 irq low", {31'h0, irq_o}, 32'h0);

    // R9 exact latency on pin 0
    wr(ADR_PEND, 32'hFFFF_FFFF);
    wr(ADR_EN_SET, 32'h0000_0001);
    wr(ADR_ACCEPT, 32'h0000_0001);
    pin_i[0] = 1'b1;
    @(negedge clk);
    rd_chk("R9 pend after 1 edge", ADR_PEND, 32'h0);
    @(negedge clk);
    rd_chk("R9 pend after 2 edges", ADR_PEND, 32'h0);
    @(negedge clk);
    rd_chk("R9 pend after 3 edges", ADR_PEND, 32'h0000_0001);
    chk("R9 irq lags status", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 irq one cycle later", {31'h0, irq_o}, 32'h1);

    // random phase against the model
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] a;
      @(negedge clk);
      bus_we = 1'b0;
      a = rd_addrs[$urandom % 11];
      bus_addr = a;
      #1;
      chk("R8 random read", bus_rdata, exp_read(a));
      chk("R9 random irq", {31'h0, irq_o}, {31'h0, m_irq});
      pin_i = pin_i ^ ($urandom & $urandom & $urandom);
      if ($urandom % 6 == 0) begin
        int sel;
        sel = $urandom % 7;
        bus_we = 1'b1;
        case (sel)
          0: begin bus_addr = ADR_EN_SET; bus_wdata = $urandom & $urandom; end
          1: begin bus_addr = ADR_EN_CLR; bus_wdata = $urandom & $urandom; end
          2: begin bus_addr = ADR_ACCEPT; bus_wdata = $urandom; end
          3: begin bus_addr = ADR_PEND;   bus_wdata = $urandom; end
          default: begin
            bus_addr = ADR_SENSE0 + 8'(4 * ($urandom % 4));
            bus_wdata = rand_sense();
          end
        endcase
      end
    end
    @(negedge clk);
    bus_we = 1'b0;

    done = 1;
    summary();
    $finish;
  end

endmodule